// File: doc/BRIEF.md
# Byte-Counted SPI Transmit Word Front End

This block sits between a simple register bus and the two data FIFOs of an SPI master. On the transmit side it turns bus writes into FIFO pushes. Each pushed entry holds a 32-bit word and a 2-bit count of how many of its bytes are valid. The length of a word is encoded by the address that is written. One address carries a complete four-byte word. Three more addresses each carry a short word of one, two or three bytes. A short word is meant to close a burst, so software writes it only once the transmit FIFO has drained.

On the receive side the block serves the data-register read. It returns the word at the head of the receive FIFO and pops it in the same access. Push, pop and read data are all combinational in the strobe cycle, so the FIFOs see each access exactly once. A write that meets a full transmit FIFO is discarded and recorded in a sticky overflow flag, which stays set until reset.

Top module: `txfront_top`

## Requirements
- R1: A write strobe at address 0x1C with the TX FIFO not full raises `txPush` in that same cycle. It passes `busWrData` unchanged and sets `txPushCnt` = 0, where 0 means all four bytes are valid.
- R2: A write strobe at address 0x80, 0x84 or 0x88 with the TX FIFO not full raises `txPush` in that cycle, with `txPushCnt` equal to 1, 2 or 3 respectively.
- R3: For a short word of N valid bytes, bytes 0 to N-1 of `txPushData` (byte k is bits 8k+7:8k) equal the bus data. Every higher byte is 0xFF, whatever the bus drove there.
- R4: A write strobe at any of the four transmit addresses while `txFull` is high produces no push. `txOverflow` is 1 from the next clock edge on and stays 1 until reset.
- R5: A read strobe at address 0x20 with the RX FIFO not empty raises `rxPop` for that one cycle, and `busRdData` equals `rxHead`.
- R6: A read strobe at address 0x20 while `rxEmpty` is high produces no pop, and `busRdData` is zero.
- R7: An access at any other address produces no push and no pop, and reads as zero. Without a strobe there is never a push or a pop, and `busRdData` is zero.
- R8: When both the write and the read strobe are high in one cycle, the write is served as in R1 to R4. The read is ignored: there is no pop and `busRdData` is zero.
- R9: While reset is asserted, `txOverflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busRdData | output | 32 | Read data, valid in the strobe cycle |
| txFull | input | 1 | TX FIFO cannot accept an entry |
| txPush | output | 1 | Push one entry into the TX FIFO |
| txPushData | output | 32 | Word pushed into the TX FIFO |
| txPushCnt | output | 2 | Valid-byte count (0 means four) |
| rxEmpty | input | 1 | RX FIFO holds no entry |
| rxHead | input | 32 | Word at the head of the RX FIFO |
| rxPop | output | 1 | Pop the RX FIFO head |
| txOverflow | output | 1 | Sticky flag, a TX write was dropped |

## Verification
The checker assumes that the FIFO flags are settled before the clock edge. It also assumes that a strobe lasts exactly one cycle per access, so a push or pop seen in a cycle belongs to that cycle's strobe. The bench drives all inputs shortly after each rising edge and holds them until the next one. It draws the FIFO flags independently of the strobes, so that full and empty coincide with every address. The bench does not rely on the short-words-only-when-empty rule, because enforcing it is left to software. Overlapping read and write strobes are applied on purpose to exercise R8.

// File: rtl/txfront_pkg.sv
package txfront_pkg;
  typedef logic [1:0] byteCnt_t;

  typedef struct packed {
    logic     push;
    logic     pop;
    logic     drop;
    byteCnt_t cnt;
  } strobes_t;
endpackage

// File: rtl/txfront_ctrl.sv
module txfront_ctrl
  import txfront_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FULL_ADDR  = 'h1C,
  parameter int PART1_ADDR = 'h80,
  parameter int PART2_ADDR = 'h84,
  parameter int PART3_ADDR = 'h88,
  parameter int RX_ADDR    = 'h20
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              txFull,
  input  logic              rxEmpty,
  output strobes_t          strb
);
  localparam int NUM_PART = 3;
  localparam logic [ADDR_W-1:0] FULL_A = ADDR_W'(FULL_ADDR);
  localparam logic [ADDR_W-1:0] RX_A   = ADDR_W'(RX_ADDR);
  localparam logic [NUM_PART*ADDR_W-1:0] PART_A =
    {ADDR_W'(PART3_ADDR), ADDR_W'(PART2_ADDR), ADDR_W'(PART1_ADDR)};

  logic [NUM_PART-1:0] partHit;
  logic                fullHit;
  logic                txHit;
  logic                rxHit;
  byteCnt_t            cnt;

  genvar p;
  generate
    for (p = 0; p < NUM_PART; p++) begin : g_part
      assign partHit[p] = busAddr == PART_A[p*ADDR_W +: ADDR_W];
    end
  endgenerate

  assign fullHit = busAddr == FULL_A;
  assign rxHit   = busAddr == RX_A;
  assign txHit   = fullHit || (|partHit);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_PART; i++) begin
      if (partHit[i]) cnt = byteCnt_t'(i + 1);
    end
  end

  always_comb begin
    strb.cnt  = cnt;
    strb.push = busWrEn && txHit && !txFull;
    strb.drop = busWrEn && txHit && txFull;
    strb.pop  = busRdEn && !busWrEn && rxHit && !rxEmpty;
  end
endmodule

// File: rtl/txfront_dpath.sv
module txfront_dpath
  import txfront_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] rxHead,
  output logic [DATA_W-1:0] busRdData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData,
  output logic [1:0]        txPushCnt,
  output logic              rxPop,
  output logic              txOverflow
);
  localparam int NBYTES = DATA_W / 8;

  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_byte
      logic keep;
      assign keep = (strb.cnt == '0) || (b < int'(strb.cnt));
      assign txPushData[b*8 +: 8] = keep ? busWrData[b*8 +: 8] : 8'hFF;
    end
  endgenerate

  assign txPush    = strb.push;
  assign txPushCnt = strb.cnt;
  assign rxPop     = strb.pop;
  assign busRdData = strb.pop ? rxHead : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txOverflow <= 1'b0;
    else if (strb.drop) txOverflow <= 1'b1;
  end
endmodule

// File: rtl/txfront_top.sv
module txfront_top
  import txfront_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              txFull,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData,
  output logic [1:0]        txPushCnt,
  input  logic              rxEmpty,
  input  logic [DATA_W-1:0] rxHead,
  output logic              rxPop,
  output logic              txOverflow
);
  strobes_t strb;

  txfront_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .txFull(txFull), .rxEmpty(rxEmpty), .strb(strb)
  );

  txfront_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .rxHead(rxHead), .busRdData(busRdData), .txPush(txPush),
    .txPushData(txPushData), .txPushCnt(txPushCnt), .rxPop(rxPop),
    .txOverflow(txOverflow)
  );
endmodule

// File: rtl/txfront_chk.sv
module txfront_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              txFull,
  input logic              txPush,
  input logic [DATA_W-1:0] txPushData,
  input logic [1:0]        txPushCnt,
  input logic              rxEmpty,
  input logic [DATA_W-1:0] rxHead,
  input logic              rxPop,
  input logic              txOverflow
);
  // R1: a full-word push carries the bus word untouched
  a_r1_full_word_intact: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txPushCnt == 2'd0) |-> txPushData == busWrData);

  // R4: a full FIFO never receives a push
  a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    txFull |-> !txPush);

  // R4: a dropped transmit write raises the flag on the next edge
  a_r4_drop_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && txFull && (busAddr == 8'h1C || busAddr == 8'h80 ||
      busAddr == 8'h84 || busAddr == 8'h88)) |=> txOverflow);

  // R4: the flag is sticky
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |=> txOverflow);

  // R6: an empty RX FIFO is never popped
  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |-> !rxPop);

  // R5: a pop returns the head word
  a_r5_pop_returns_head: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (busRdData == rxHead && busRdEn));

  // R8: at most one FIFO action per access
  a_r8_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txPush, rxPop}));

  // R7: without a strobe nothing moves
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !busRdEn) |-> (!txPush && !rxPop && busRdData == '0));
endmodule

bind txfront_top txfront_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .txFull(txFull), .txPush(txPush), .txPushData(txPushData),
  .txPushCnt(txPushCnt), .rxEmpty(rxEmpty), .rxHead(rxHead),
  .rxPop(rxPop), .txOverflow(txOverflow)
);

// File: tb/txfront_top_bench.sv
module txfront_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        txFull = 1'b0;
  logic        txPush;
  logic [31:0] txPushData;
  logic [1:0]  txPushCnt;
  logic        rxEmpty = 1'b1;
  logic [31:0] rxHead = '0;
  logic        rxPop;
  logic        txOverflow;

  int nChecks = 0;
  int nFails  = 0;
  bit mOvf = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  txfront_top u_txfront_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txFull(txFull), .txPush(txPush), .txPushData(txPushData),
    .txPushCnt(txPushCnt), .rxEmpty(rxEmpty), .rxHead(rxHead),
    .rxPop(rxPop), .txOverflow(txOverflow)
  );

  function automatic int txLen(input logic [7:0] a);
    case (a)
      8'h1C:   return 4;
      8'h80:   return 1;
      8'h84:   return 2;
      8'h88:   return 3;
      default: return 0;
    endcase
  endfunction

  // reference model of the sticky flag
  always @(posedge clk or negedge rstN) begin
    if (!rstN) mOvf <= 1'b0;
    else if (busWrEn && txLen(busAddr) != 0 && txFull) mOvf <= 1'b1;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int    n   = txLen(busAddr);
    bit    eP  = busWrEn && n != 0 && !txFull;
    bit    eR  = busRdEn && !busWrEn && busAddr == 8'h20 && !rxEmpty;
    string tW, tR;
    logic [31:0] eD = busWrData;
    if (n == 4 || n == 0) tW = "R1";
    else tW = "R2";
    if (busWrEn && n != 0 && txFull) tW = "R4";
    if (!busWrEn || n == 0) tW = "R7";
    if (busWrEn && busRdEn) tR = "R8";
    else if (busRdEn && busAddr == 8'h20) tR = rxEmpty ? "R6" : "R5";
    else tR = "R7";
    chk(tW, "txPush", 32'(txPush), 32'(eP));
    chk(tR, "rxPop", 32'(rxPop), 32'(eR));
    chk(tR, "busRdData", busRdData, eR ? rxHead : 32'h0);
    if (eP) begin
      if (n < 4) begin
        for (int k = n; k < 4; k++) eD[k*8 +: 8] = 8'hFF;
        chk("R3", "txPushData", txPushData, eD);
      end else begin
        chk("R1", "txPushData", txPushData, eD);
      end
      chk(n == 4 ? "R1" : "R2", "txPushCnt", 32'(txPushCnt), 32'(n % 4));
    end
    chk(rstN ? "R4" : "R9", "txOverflow", 32'(txOverflow), 32'(mOvf));
  endtask

  task automatic cyc(input logic [7:0] a, input bit w, input bit r,
                     input logic [31:0] d, input bit full, input bit emp,
                     input logic [31:0] head);
    @(posedge clk);
    #2;
    busAddr = a; busWrEn = w; busRdEn = r; busWrData = d;
    txFull = full; rxEmpty = emp; rxHead = head;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    @(negedge clk);
    compare();
    cyc(8'h1C, 1, 0, 32'h11223344, 1, 1, 0); // R4 during reset: flag must stay 0
    @(posedge clk); #2 rstN = 1'b1;
    // R1
    cyc(8'h1C, 1, 0, 32'hA1B2C3D4, 0, 1, 0);
    // R2, R3
    cyc(8'h80, 1, 0, 32'h12345678, 0, 1, 0);
    cyc(8'h84, 1, 0, 32'h12345678, 0, 1, 0);
    cyc(8'h88, 1, 0, 32'h12345678, 0, 1, 0);
    // R5, R6
    cyc(8'h20, 0, 1, 0, 0, 0, 32'hCAFEF00D);
    cyc(8'h20, 0, 1, 0, 0, 1, 32'hCAFEF00D);
    // R7
    cyc(8'h24, 1, 0, 32'h55AA55AA, 0, 0, 32'h1);
    cyc(8'h1C, 0, 1, 0, 0, 0, 32'h2);
    cyc(8'h20, 0, 0, 0, 0, 0, 32'h3);
    // R8
    cyc(8'h20, 1, 1, 32'h9, 0, 0, 32'h4);
    cyc(8'h84, 1, 1, 32'hDEADBEEF, 0, 0, 32'h5);
    // R4: drop, then sticky
    cyc(8'h88, 1, 0, 32'h77777777, 1, 1, 0);
    cyc(8'h00, 0, 0, 0, 0, 1, 0);
    cyc(8'h1C, 1, 0, 32'h01020304, 0, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h1C; 1: a = 8'h80; 2: a = 8'h84; 3: a = 8'h88;
        4: a = 8'h20; default: a = 8'($urandom);
      endcase
      cyc(a, 1'($urandom), 1'($urandom), $urandom, ($urandom_range(0, 3) == 0),
          1'($urandom), $urandom);
    end
    // R9: reset clears the flag
    @(posedge clk); #2 rstN = 1'b0; busWrEn = 0; busRdEn = 0;
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule